// File: doc/BRIEF.md
# Single-Shunt Sampling Window Scheduler

This block sits beside a centre-aligned three-phase PWM timer. The timer counts up and down between zero and a programmable top. The block reads the timer count each clock. Each PWM cycle it takes the three requested phase compare values, and it returns two sets of compare values: one for the half that counts down (the left half) and one for the half that counts up (the right half). It also produces three one-cycle trigger strobes for the converter that samples the DC-link shunt resistor.

A phase is on while the count is below its compare value. In the left half the phase with the largest compare turns on first. The two active-vector intervals are therefore the span between the largest and middle compare values and the span between the middle and smallest. Both currents are sampled in the left half only. If an interval is shorter than the minimum measurement window, the block moves the outer edge outward in the left half so the interval is as wide as the window. It then moves the same edge inward by the same amount in the right half, so each phase keeps its total on-time over the cycle. The window is the sum of four programmable parts: switch settling, amplifier settling, conversion time and dead time.

The block also registers the switching order and a sector code for the current-reconstruction stage. Left values take effect at the counter-zero event and right values at the counter-top event. This way one PWM cycle always uses one coherent set.

Top module: `ssw_sched`

## Requirements
- R1: While `rst_n` is low, every compare, order, sector, flag and trigger output is zero.
- R2: At the counter-zero event the block registers the sort of the requests. `ord_first` and `ord_second` hold the phase index (0 = a, 1 = b, 2 = c) of the largest and middle request, with ties going to the lower index. `sector` bit 0 is a>=b, bit 1 is b>=c and bit 2 is c>=a.
- R3: When both active intervals (largest minus middle, middle minus smallest) are at least the window, the left and right compare values equal the requests.
- R4: When only the first interval is short, the largest phase's left value becomes middle + window and its right value becomes twice its request minus that left value. The other phases are unchanged.
- R5: When only the second interval is short, the smallest phase's left value becomes middle minus window and its right value becomes twice its request minus that left value.
- R6: When both intervals are short, both corrections of R4 and R5 apply in the same cycle.
- R7: Any stretched value below zero or above `period` is clamped to that limit, and `win_sat` is set for that cycle's set.
- R8: Left outputs, order, sector and `win_sat` change only in the clock after the count equals zero. Right outputs change only in the clock after the count equals `period`, and they take the set computed at the preceding zero event.
- R9: `trig_first` pulses for one clock after a clock where `cnt_up` is low and the count equals the largest phase's left value minus (dead time + switch settling + amplifier settling).
- R10: `trig_second` pulses one clock after a down-counting clock whose count equals the middle value minus the same offset. It fires only once `trig_first` has fired in that left half, and it is disarmed at the zero event.
- R11: `trig_aux` pulses for one clock after a clock where `cnt_up` is high and the count equals `aux_pos`. At most one trigger is high in any clock.
- R12: The window used for stretching is the sum `t_sw + t_amp + t_adc + t_dead`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | W | PWM timer count |
| cnt_up | input | 1 | 1 while the timer counts up (right half), 0 while it counts down (left half) |
| period | input | W | Timer top value |
| req_a | input | W | Requested compare, phase a |
| req_b | input | W | Requested compare, phase b |
| req_c | input | W | Requested compare, phase c |
| t_sw | input | TW | Switch turn-on settling time in counts |
| t_amp | input | TW | Amplifier settling time in counts |
| t_adc | input | TW | Conversion time in counts |
| t_dead | input | TW | Dead time in counts |
| aux_pos | input | W | Count for the auxiliary trigger in the right half |
| left_a | output | W | Left-half compare, phase a |
| left_b | output | W | Left-half compare, phase b |
| left_c | output | W | Left-half compare, phase c |
| right_a | output | W | Right-half compare, phase a |
| right_b | output | W | Right-half compare, phase b |
| right_c | output | W | Right-half compare, phase c |
| trig_first | output | 1 | First-interval sample strobe |
| trig_second | output | 1 | Second-interval sample strobe |
| trig_aux | output | 1 | Auxiliary sample strobe |
| win_sat | output | 1 | A stretched edge was clamped |
| ord_first | output | 2 | Index of the phase switching first |
| ord_second | output | 2 | Index of the phase switching second |
| sector | output | 3 | Pairwise comparison code of the requests |

## Verification
The scheduler is driven with six request sets, each held over two full PWM cycles while a bench model tracks every output:
- Wide spacing on both intervals, which must pass through unchanged.
- A short first interval alone, and a short second interval alone, with a different phase leading in each. These separate the two stretch paths and test that the sort order maps back to the right phase.
- Both intervals short at once.
- A short interval next to the top count, which forces a clamp and the saturation flag.
- A changed set of window parts, which confirms that the window is their sum and not a fixed value.

One further check changes the requests partway through a half-cycle, to show that nothing moves before the next load event.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  localparam int NUM_PH = 3;
  typedef logic [1:0] ph_idx_t;
endpackage

// File: rtl/ssw_sort.sv
module ssw_sort
  import ssw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  input  logic [W-1:0] req_c,
  output ph_idx_t      first,
  output ph_idx_t      second,
  output logic [W-1:0] hi,
  output logic [W-1:0] mid,
  output logic [W-1:0] lo
);
  ph_idx_t third;

  function automatic logic [W-1:0] pick(input ph_idx_t i, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic [W-1:0] c);
    pick = (i == 2'd0) ? a : (i == 2'd1) ? b : c;
  endfunction

  // Stable descending order: ties resolve to the lower phase index.
  always_comb begin
    if (req_a >= req_b && req_a >= req_c) first = 2'd0;
    else if (req_b >= req_c)              first = 2'd1;
    else                                  first = 2'd2;
    case (first)
      2'd0:    second = (req_b >= req_c) ? 2'd1 : 2'd2;
      2'd1:    second = (req_a >= req_c) ? 2'd0 : 2'd2;
      default: second = (req_a >= req_b) ? 2'd0 : 2'd1;
    endcase
    third = 2'd3 - first - second;
  end

  assign hi  = pick(first,  req_a, req_b, req_c);
  assign mid = pick(second, req_a, req_b, req_c);
  assign lo  = pick(third,  req_a, req_b, req_c);
endmodule

// File: rtl/ssw_stretch.sv
module ssw_stretch #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         hi,
  input  logic [W-1:0]         mid,
  input  logic [W-1:0]         lo,
  input  logic [W-1:0]         period,
  input  logic [W:0]           win,
  input  logic [W:0]           off,
  output logic [W-1:0]         hi_l,
  output logic [W-1:0]         hi_r,
  output logic [W-1:0]         lo_l,
  output logic [W-1:0]         lo_r,
  output logic signed [W+2:0]  t1,
  output logic signed [W+2:0]  t2,
  output logic                 sat
);
  localparam int SW = W + 3;

  logic signed [SW-1:0] h, m, l, p, w, o;
  logic signed [SW-1:0] hl_raw, hr_raw, ll_raw, lr_raw;
  logic                 short1, short2;

  function automatic logic outside(input logic signed [SW-1:0] v, input logic signed [SW-1:0] top);
    outside = (v < 0) || (v > top);
  endfunction

  function automatic logic [W-1:0] clampv(input logic signed [SW-1:0] v, input logic signed [SW-1:0] top);
    logic signed [SW-1:0] r;
    if (v < 0)        r = '0;
    else if (v > top) r = top;
    else              r = v;
    clampv = r[W-1:0];
  endfunction

  always_comb begin
    h = $signed({3'b000, hi});
    m = $signed({3'b000, mid});
    l = $signed({3'b000, lo});
    p = $signed({3'b000, period});
    w = $signed({2'b00, win});
    o = $signed({2'b00, off});
    short1 = (h - m) < w;
    short2 = (m - l) < w;
    hl_raw = short1 ? (m + w) : h;
    hr_raw = short1 ? ((h <<< 1) - (m + w)) : h;
    ll_raw = short2 ? (m - w) : l;
    lr_raw = short2 ? ((l <<< 1) - (m - w)) : l;
  end

  assign hi_l = clampv(hl_raw, p);
  assign hi_r = clampv(hr_raw, p);
  assign lo_l = clampv(ll_raw, p);
  assign lo_r = clampv(lr_raw, p);
  assign sat  = outside(hl_raw, p) | outside(hr_raw, p) | outside(ll_raw, p) | outside(lr_raw, p);
  assign t1   = $signed({3'b000, hi_l}) - o;
  assign t2   = m - o;

  AST_BALANCE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !sat |-> (({1'b0, hi_l} + {1'b0, hi_r}) == {hi, 1'b0})) else $error("hi balance"); // R4
  AST_BALANCE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !sat |-> (({1'b0, lo_l} + {1'b0, lo_r}) == {lo, 1'b0})) else $error("lo balance"); // R5
endmodule

// File: rtl/ssw_trig.sv
module ssw_trig #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        cnt,
  input  logic                cnt_up,
  input  logic                zero_evt,
  input  logic signed [W+2:0] t1,
  input  logic signed [W+2:0] t2,
  input  logic [W-1:0]        aux,
  output logic                trig_first,
  output logic                trig_second,
  output logic                trig_aux
);
  logic signed [W+2:0] cs;
  logic hit1, hit2, hit3, armed_q, armed_n;

  always_comb begin
    cs   = $signed({3'b000, cnt});
    hit1 = !cnt_up && (cs == t1);
    hit2 = armed_q && !cnt_up && (cs == t2);
    hit3 = cnt_up && (cnt == aux);
    armed_n = armed_q;
    if (zero_evt)  armed_n = 1'b0;
    else if (hit1) armed_n = 1'b1;
    else if (hit2) armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      trig_first  <= 1'b0;
      trig_second <= 1'b0;
      trig_aux    <= 1'b0;
    end else begin
      armed_q     <= armed_n;
      trig_first  <= hit1;
      trig_second <= hit2;
      trig_aux    <= hit3;
    end
  end

  AST_FIRST_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    trig_first |-> $past(!cnt_up)) else $error("first trigger outside left half"); // R9
  AST_SECOND_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    trig_second |-> $past(!cnt_up)) else $error("second trigger outside left half"); // R10
  AST_AUX_UP: assert property (@(posedge clk) disable iff (!rst_n)
    trig_aux |-> $past(cnt_up)) else $error("aux trigger outside right half"); // R11
  AST_TRIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_first, trig_second, trig_aux})) else $error("trigger overlap"); // R11
endmodule

// File: rtl/ssw_sched.sv
module ssw_sched
  import ssw_pkg::*;
#(
  parameter int W  = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cnt,
  input  logic          cnt_up,
  input  logic [W-1:0]  period,
  input  logic [W-1:0]  req_a,
  input  logic [W-1:0]  req_b,
  input  logic [W-1:0]  req_c,
  input  logic [TW-1:0] t_sw,
  input  logic [TW-1:0] t_amp,
  input  logic [TW-1:0] t_adc,
  input  logic [TW-1:0] t_dead,
  input  logic [W-1:0]  aux_pos,
  output logic [W-1:0]  left_a,
  output logic [W-1:0]  left_b,
  output logic [W-1:0]  left_c,
  output logic [W-1:0]  right_a,
  output logic [W-1:0]  right_b,
  output logic [W-1:0]  right_c,
  output logic          trig_first,
  output logic          trig_second,
  output logic          trig_aux,
  output logic          win_sat,
  output logic [1:0]    ord_first,
  output logic [1:0]    ord_second,
  output logic [2:0]    sector
);
  localparam int NP = NUM_PH;
  localparam int SW = W + 3;

  logic [W:0]          win_c, off_c;
  logic                zero_evt, top_evt;
  ph_idx_t             s_first, s_second;
  logic [W-1:0]        v_hi, v_mid, v_lo, hi_l, hi_r, lo_l, lo_r;
  logic signed [SW-1:0] c_t1, c_t2;
  logic                c_sat;
  logic [2:0]          c_sec;
  logic [W-1:0]        l_new [NP];
  logic [W-1:0]        r_new [NP];

  // Register state and next-state
  logic [W-1:0]        left_q [NP], left_n [NP];
  logic [W-1:0]        pend_q [NP], pend_n [NP];
  logic [W-1:0]        right_q [NP], right_n [NP];
  logic signed [SW-1:0] pt1_q, pt1_n, pt2_q, pt2_n, at1_q, at1_n, at2_q, at2_n;
  ph_idx_t             first_q, first_n, second_q, second_n;
  logic [2:0]          sec_q, sec_n;
  logic                sat_q, sat_n;
  logic [W:0]          win_q, win_n;

  assign win_c = (W+1)'(t_sw) + (W+1)'(t_amp) + (W+1)'(t_adc) + (W+1)'(t_dead);
  assign off_c = (W+1)'(t_sw) + (W+1)'(t_amp) + (W+1)'(t_dead);
  assign zero_evt = (cnt == '0);
  assign top_evt  = (cnt == period);
  assign c_sec = {req_c >= req_a, req_b >= req_c, req_a >= req_b};

  ssw_sort #(.W(W)) u_sort (
    .req_a(req_a), .req_b(req_b), .req_c(req_c),
    .first(s_first), .second(s_second), .hi(v_hi), .mid(v_mid), .lo(v_lo)
  );

  ssw_stretch #(.W(W)) u_stretch (
    .clk(clk), .rst_n(rst_n), .hi(v_hi), .mid(v_mid), .lo(v_lo), .period(period),
    .win(win_c), .off(off_c), .hi_l(hi_l), .hi_r(hi_r), .lo_l(lo_l), .lo_r(lo_r),
    .t1(c_t1), .t2(c_t2), .sat(c_sat)
  );

  // Map stretched edges back onto phases
  for (genvar p = 0; p < NP; p++) begin : g_map
    assign l_new[p] = (s_first == ph_idx_t'(p)) ? hi_l :
                      (s_second == ph_idx_t'(p)) ? v_mid : lo_l;
    assign r_new[p] = (s_first == ph_idx_t'(p)) ? hi_r :
                      (s_second == ph_idx_t'(p)) ? v_mid : lo_r;
  end

  always_comb begin
    left_n = left_q;   pend_n = pend_q;   right_n = right_q;
    pt1_n = pt1_q;     pt2_n = pt2_q;     at1_n = at1_q;   at2_n = at2_q;
    first_n = first_q; second_n = second_q; sec_n = sec_q; sat_n = sat_q;
    win_n = win_q;
    if (zero_evt) begin
      left_n = l_new;  pend_n = r_new;
      pt1_n = c_t1;    pt2_n = c_t2;
      first_n = s_first; second_n = s_second; sec_n = c_sec; sat_n = c_sat;
      win_n = win_c;
    end
    if (top_evt) begin
      right_n = pend_q;
      at1_n = pt1_q;   at2_n = pt2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        left_q[i] <= '0; pend_q[i] <= '0; right_q[i] <= '0;
      end
      pt1_q <= '0; pt2_q <= '0; at1_q <= '0; at2_q <= '0;
      first_q <= '0; second_q <= '0; sec_q <= '0; sat_q <= 1'b0; win_q <= '0;
    end else begin
      left_q <= left_n; pend_q <= pend_n; right_q <= right_n;
      pt1_q <= pt1_n; pt2_q <= pt2_n; at1_q <= at1_n; at2_q <= at2_n;
      first_q <= first_n; second_q <= second_n; sec_q <= sec_n; sat_q <= sat_n;
      win_q <= win_n;
    end
  end

  ssw_trig #(.W(W)) u_trig (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up), .zero_evt(zero_evt),
    .t1(at1_q), .t2(at2_q), .aux(aux_pos),
    .trig_first(trig_first), .trig_second(trig_second), .trig_aux(trig_aux)
  );

  assign left_a  = left_q[0];  assign left_b  = left_q[1];  assign left_c  = left_q[2];
  assign right_a = right_q[0]; assign right_b = right_q[1]; assign right_c = right_q[2];
  assign win_sat = sat_q;
  assign ord_first = first_q;
  assign ord_second = second_q;
  assign sector = sec_q;

  function automatic logic [W-1:0] lsel(input ph_idx_t i, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic [W-1:0] c);
    lsel = (i == 2'd0) ? a : (i == 2'd1) ? b : c;
  endfunction

  AST_GAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_sat && first_q != second_q) |->
      ({1'b0, lsel(first_q, left_a, left_b, left_c)} >=
       {1'b0, lsel(second_q, left_a, left_b, left_c)} + win_q)) else $error("gap below window"); // R12
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q != second_q) |->
      (lsel(first_q, left_a, left_b, left_c) >= lsel(second_q, left_a, left_b, left_c))) else $error("order lost"); // R2
  AST_LEFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({left_a, left_b, left_c}) |-> $past(zero_evt)) else $error("left moved off zero"); // R8
  AST_RIGHT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({right_a, right_b, right_c}) |-> $past(top_evt)) else $error("right moved off top"); // R8
endmodule

// File: tb/tb_ssw_sched.sv
`timescale 1ns/1ps
module tb_ssw_sched;
  localparam int W = 16;
  localparam int TW = 8;
  localparam int P = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] cnt, period, req_a, req_b, req_c, aux_pos;
  logic cnt_up;
  logic [TW-1:0] t_sw, t_amp, t_adc, t_dead;
  logic [W-1:0] left_a, left_b, left_c, right_a, right_b, right_c;
  logic trig_first, trig_second, trig_aux, win_sat;
  logic [1:0] ord_first, ord_second;
  logic [2:0] sector;

  int checks = 0;
  int errors = 0;
  int seen_t1 = -1, seen_t2 = -1, seen_t3 = -1;

  always #2.5 clk = ~clk;

  ssw_sched #(.W(W), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up), .period(period),
    .req_a(req_a), .req_b(req_b), .req_c(req_c),
    .t_sw(t_sw), .t_amp(t_amp), .t_adc(t_adc), .t_dead(t_dead), .aux_pos(aux_pos),
    .left_a(left_a), .left_b(left_b), .left_c(left_c),
    .right_a(right_a), .right_b(right_b), .right_c(right_c),
    .trig_first(trig_first), .trig_second(trig_second), .trig_aux(trig_aux),
    .win_sat(win_sat), .ord_first(ord_first), .ord_second(ord_second), .sector(sector)
  );

  // Behavioural reference model
  int mL[3], mR[3], mPend[3];
  int mPt1, mPt2, mAt1, mAt2, mF, mS, mSec, mSat;
  bit mArm, mT1, mT2, mT3;
  int cL[3], cR[3];
  int ct1, ct2, cf, cs, csat;

  function automatic int clip(int v, int top, inout int flag);
    if (v < 0) begin flag = 1; return 0; end
    if (v > top) begin flag = 1; return top; end
    return v;
  endfunction

  task automatic calc(int a, int b, int c, int per, int win, int off);
    int v[3];
    int idx[3];
    int hi, mid, lo, hl, hr, ll, lr, tmp;
    v[0] = a; v[1] = b; v[2] = c;
    idx[0] = 0; idx[1] = 1; idx[2] = 2;
    for (int pass = 0; pass < 2; pass++)
      for (int j = 0; j < 2; j++)
        if (v[idx[j+1]] > v[idx[j]]) begin
          tmp = idx[j]; idx[j] = idx[j+1]; idx[j+1] = tmp;
        end
    hi = v[idx[0]]; mid = v[idx[1]]; lo = v[idx[2]];
    if (hi - mid < win) begin hl = mid + win; hr = 2*hi - hl; end
    else begin hl = hi; hr = hi; end
    if (mid - lo < win) begin ll = mid - win; lr = 2*lo - ll; end
    else begin ll = lo; lr = lo; end
    csat = 0;
    hl = clip(hl, per, csat); hr = clip(hr, per, csat);
    ll = clip(ll, per, csat); lr = clip(lr, per, csat);
    cL[idx[0]] = hl; cL[idx[1]] = mid; cL[idx[2]] = ll;
    cR[idx[0]] = hr; cR[idx[1]] = mid; cR[idx[2]] = lr;
    ct1 = hl - off; ct2 = mid - off; cf = idx[0]; cs = idx[1];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin mL[i] <= 0; mR[i] <= 0; mPend[i] <= 0; end
      mPt1 <= 0; mPt2 <= 0; mAt1 <= 0; mAt2 <= 0; mF <= 0; mS <= 0; mSec <= 0; mSat <= 0;
      mArm <= 0; mT1 <= 0; mT2 <= 0; mT3 <= 0;
    end else begin
      bit h1, h2;
      calc(int'(req_a), int'(req_b), int'(req_c), int'(period),
           int'(t_sw) + int'(t_amp) + int'(t_adc) + int'(t_dead),
           int'(t_sw) + int'(t_amp) + int'(t_dead));
      h1 = !cnt_up && int'(cnt) == mAt1;
      h2 = mArm && !cnt_up && int'(cnt) == mAt2;
      mT1 <= h1; mT2 <= h2; mT3 <= cnt_up && cnt == aux_pos;
      if (cnt == 0) mArm <= 0; else if (h1) mArm <= 1; else if (h2) mArm <= 0;
      if (cnt == 0) begin
        mL <= cL; mPend <= cR; mPt1 <= ct1; mPt2 <= ct2; mF <= cf; mS <= cs; mSat <= csat;
        mSec <= (req_c >= req_a ? 4 : 0) + (req_b >= req_c ? 2 : 0) + (req_a >= req_b ? 1 : 0);
      end
      if (cnt == period) begin mR <= mPend; mAt1 <= mPt1; mAt2 <= mPt2; end
    end
  end

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(left_a), mL[0], "R8 left_a");   chk(int'(left_b), mL[1], "R8 left_b");
    chk(int'(left_c), mL[2], "R8 left_c");   chk(int'(right_a), mR[0], "R8 right_a");
    chk(int'(right_b), mR[1], "R8 right_b"); chk(int'(right_c), mR[2], "R8 right_c");
    chk(int'(ord_first), mF, "R2 ord_first"); chk(int'(ord_second), mS, "R2 ord_second");
    chk(int'(sector), mSec, "R2 sector");    chk(int'(win_sat), mSat, "R7 win_sat");
    chk(int'(trig_first), int'(mT1), "R9 trig_first");
    chk(int'(trig_second), int'(mT2), "R10 trig_second");
    chk(int'(trig_aux), int'(mT3), "R11 trig_aux");
    if (trig_first)  seen_t1 = int'(cnt);
    if (trig_second) seen_t2 = int'(cnt);
    if (trig_aux)    seen_t3 = int'(cnt);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      if (cnt_up) begin
        if (int'(cnt) == P - 1) begin cnt = W'(P); cnt_up = 1'b0; end
        else cnt = cnt + 1'b1;
      end else begin
        if (int'(cnt) == 1) begin cnt = '0; cnt_up = 1'b1; end
        else cnt = cnt - 1'b1;
      end
    end
  endtask

  task automatic set_req(int a, int b, int c);
    req_a = W'(a); req_b = W'(b); req_c = W'(c);
  endtask

  task automatic chk_set(int la, int lb, int lc, int ra, int rb, int rc, string tag);
    chk(int'(left_a), la, tag);  chk(int'(left_b), lb, tag);  chk(int'(left_c), lc, tag);
    chk(int'(right_a), ra, tag); chk(int'(right_b), rb, tag); chk(int'(right_c), rc, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cnt = '0; cnt_up = 1'b1; period = W'(P); aux_pos = W'(30);
    t_sw = 8'd4; t_amp = 8'd3; t_adc = 8'd5; t_dead = 8'd2;
    set_req(150, 100, 50);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_set(0, 0, 0, 0, 0, 0, "R1 compares");
    chk(int'({trig_first, trig_second, trig_aux, win_sat}), 0, "R1 flags");
    chk(int'({ord_first, ord_second, sector}), 0, "R1 order/sector");
    rst_n = 1'b1;

    // R3: wide intervals pass through; triggers at 141, 91 and aux 30
    step(4 * 2 * P);
    chk_set(150, 100, 50, 150, 100, 50, "R3 passthrough");
    chk(seen_t1, 141, "R9 first trigger count");
    chk(seen_t2, 91, "R10 second trigger count");
    chk(seen_t3, 30, "R11 aux trigger count");
    chk(int'(win_sat), 0, "R7 no saturation");

    // R8: new requests mid half do not move outputs before the next zero event
    step(3);
    set_req(120, 110, 40);
    step(100);
    chk_set(150, 100, 50, 150, 100, 50, "R8 hold until event");

    // R4: first interval short (A=14): a -> 124 left, 116 right
    step(4 * P);
    chk_set(124, 110, 40, 116, 110, 40, "R4 stretch first");
    chk(int'(sector), 3, "R2 sector a>b>c");
    chk(seen_t1, 115, "R9 stretched trigger count");

    // R5: second interval short: b leads, c -> 46 left, 64 right
    set_req(60, 130, 55);
    step(4 * P);
    chk_set(60, 130, 46, 60, 130, 64, "R5 stretch second");
    chk(int'(ord_first), 1, "R2 first is b");
    chk(int'(ord_second), 0, "R2 second is a");
    chk(int'(sector), 2, "R2 sector b>a>c");

    // R6: both intervals short
    set_req(100, 105, 98);
    step(4 * P);
    chk_set(100, 114, 86, 100, 96, 110, "R6 stretch both");

    // R7: clamp at the top count
    set_req(198, 195, 3);
    step(4 * P);
    chk_set(200, 195, 3, 187, 195, 3, "R7 clamp");
    chk(int'(win_sat), 1, "R7 saturation flag");

    // R12: window parts 10+0+0+0
    t_sw = 8'd10; t_amp = 8'd0; t_adc = 8'd0; t_dead = 8'd0;
    set_req(100, 95, 20);
    step(4 * P);
    chk_set(105, 95, 20, 95, 95, 20, "R12 window sum");
    chk(seen_t1, 95, "R12 trigger offset");
    chk(int'(win_sat), 0, "R12 no saturation");

    summary();
  end
endmodule